// File: doc/BRIEF.md
# Processor Datapath Operand and Program-Counter Steering

This block sits in the datapath of a small 8-bit processor and does the steering between the storage and arithmetic parts. It forms the register-file write data through two stages of selection. The first stage picks between external input data and a constant from the control unit. The second stage picks between that result and the shifter output. It also chooses the ALU B operand from register read port B or a control-supplied immediate.

The block holds the zero and carry flags, which load from the ALU only when control asks. It holds a 10-bit program counter that either steps forward by one or jumps to a control-supplied address. It also forms a return address by adding one to the stack read data. Every strobe and select comes from an external control unit. The register file, ALU, shifter and stack connect only through ports.

Top module: `dp_steer`

## Requirements
- R1: With `sel_shift` low, `wb_data` equals `const_data` when `sel_const` is 1 and `ext_data` when `sel_const` is 0 (combinational).
- R2: With `sel_shift` high, `wb_data` equals `shift_data` whatever `sel_const` is (combinational).
- R3: `alu_b` equals `portb_data` when `sel_imm` is 0 and `imm_data` when `sel_imm` is 1 (combinational).
- R4: On a rising clock edge with `flag_ld` high and `rst` low, `zero_flag` and `carry_flag` take the values of `alu_zero` and `alu_carry`.
- R5: On a rising clock edge with `flag_ld` low and `rst` low, both flags keep their values, whatever the ALU flag inputs are.
- R6: On a rising clock edge with `pc_ld` high, `pc_jump` low and `rst` low, `pc` becomes `pc + 1` modulo 1024, so 1023 wraps to 0.
- R7: On a rising clock edge with `pc_ld` high, `pc_jump` high and `rst` low, `pc` becomes `jump_addr`.
- R8: On a rising clock edge with `pc_ld` low and `rst` low, `pc` holds, whatever `pc_jump` and `jump_addr` are.
- R9: `ret_addr` equals `stack_data + 1` modulo 1024, so 1023 gives 0 (combinational).
- R10: On a rising clock edge with `rst` high, `pc`, `zero_flag` and `carry_flag` become 0. This takes priority over `pc_ld` and `flag_ld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_data | input | 8 | External input data |
| const_data | input | 8 | Constant from control |
| shift_data | input | 8 | Shifter output |
| sel_const | input | 1 | First stage: 1 = constant, 0 = external data |
| sel_shift | input | 1 | Second stage: 1 = shifter, 0 = first-stage result |
| wb_data | output | 8 | Register-file write data |
| portb_data | input | 8 | Register read port B |
| imm_data | input | 8 | Immediate from control |
| sel_imm | input | 1 | 1 = immediate, 0 = port B |
| alu_b | output | 8 | ALU B operand |
| alu_zero | input | 1 | ALU zero result |
| alu_carry | input | 1 | ALU carry result |
| flag_ld | input | 1 | Flag load strobe |
| zero_flag | output | 1 | Registered zero flag |
| carry_flag | output | 1 | Registered carry flag |
| pc_ld | input | 1 | Program-counter load strobe |
| pc_jump | input | 1 | 1 = load jump address, 0 = increment |
| jump_addr | input | 10 | Next-instruction address from control |
| pc | output | 10 | Program counter |
| stack_data | input | 10 | Stack read data |
| ret_addr | output | 10 | Stack data plus one |

## Verification
The flag capture and the program-counter update are independent registers, and both can fall on the same clock edge. The bench provokes this by raising `flag_ld` together with a jump, and again together with an increment at the wrap point. It then checks after that single edge that both flags and the counter have taken their new values. It also raises reset together with both strobes and expects every register to clear.

// File: rtl/dp_steer_pkg.sv
package dp_steer_pkg;
    localparam int DATA_W = 8;
    localparam int PC_W   = 10;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [PC_W-1:0]   addr_t;

    typedef struct packed {
        logic zero;
        logic carry;
    } flags_t;

    typedef enum logic {
        L1_INPUT = 1'b0,
        L1_CONST = 1'b1
    } l1_src_e;

    function automatic addr_t addr_next(input addr_t a);
        return addr_t'(a + addr_t'(1));
    endfunction
endpackage

// File: rtl/dp_wb_mux.sv
module dp_wb_mux
    import dp_steer_pkg::*;
(
    input  byte_t ext_data,
    input  byte_t const_data,
    input  byte_t shift_data,
    input  logic  sel_const,
    input  logic  sel_shift,
    input  byte_t portb_data,
    input  byte_t imm_data,
    input  logic  sel_imm,
    output byte_t wb_data,
    output byte_t alu_b
);
    l1_src_e l1_src;
    byte_t   stage1;

    always_comb begin
        l1_src = l1_src_e'(sel_const);
        case (l1_src)
            L1_CONST: stage1 = const_data;
            default:  stage1 = ext_data;
        endcase
        wb_data = sel_shift ? shift_data : stage1;
        alu_b   = sel_imm ? imm_data : portb_data;
    end
endmodule

// File: rtl/dp_flag_reg.sv
module dp_flag_reg
    import dp_steer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flag_ld,
    input  flags_t alu_flags,
    output flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else if (flag_ld)
            flags <= alu_flags;
    end

    p_flag_load_r4: assert property (@(posedge clk) disable iff (rst)
        flag_ld |=> flags == $past(alu_flags));
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !flag_ld |=> $stable(flags));
endmodule

// File: rtl/dp_pc_unit.sv
module dp_pc_unit
    import dp_steer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pc_ld,
    input  logic  pc_jump,
    input  addr_t jump_addr,
    input  addr_t stack_data,
    output addr_t pc,
    output addr_t ret_addr
);
    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (pc_ld)
            pc <= pc_jump ? jump_addr : addr_next(pc);
    end

    always_comb ret_addr = addr_next(stack_data);

    p_pc_inc_r6: assert property (@(posedge clk) disable iff (rst)
        (pc_ld && !pc_jump) |=> pc == addr_t'($past(pc) + addr_t'(1)));
    p_pc_jump_r7: assert property (@(posedge clk) disable iff (rst)
        (pc_ld && pc_jump) |=> pc == $past(jump_addr));
    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !pc_ld |=> $stable(pc));
    p_pc_reset_r10: assert property (@(posedge clk)
        rst |=> pc == '0);
endmodule

// File: rtl/dp_steer.sv
module dp_steer
    import dp_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ext_data,
    input  logic [DATA_W-1:0] const_data,
    input  logic [DATA_W-1:0] shift_data,
    input  logic              sel_const,
    input  logic              sel_shift,
    output logic [DATA_W-1:0] wb_data,
    input  logic [DATA_W-1:0] portb_data,
    input  logic [DATA_W-1:0] imm_data,
    input  logic              sel_imm,
    output logic [DATA_W-1:0] alu_b,
    input  logic              alu_zero,
    input  logic              alu_carry,
    input  logic              flag_ld,
    output logic              zero_flag,
    output logic              carry_flag,
    input  logic              pc_ld,
    input  logic              pc_jump,
    input  logic [PC_W-1:0]   jump_addr,
    output logic [PC_W-1:0]   pc,
    input  logic [PC_W-1:0]   stack_data,
    output logic [PC_W-1:0]   ret_addr
);
    flags_t alu_flags;
    flags_t flags_q;

    assign alu_flags = '{zero: alu_zero, carry: alu_carry};
    assign zero_flag  = flags_q.zero;
    assign carry_flag = flags_q.carry;

    dp_wb_mux u_mux (
        .ext_data  (ext_data),
        .const_data(const_data),
        .shift_data(shift_data),
        .sel_const (sel_const),
        .sel_shift (sel_shift),
        .portb_data(portb_data),
        .imm_data  (imm_data),
        .sel_imm   (sel_imm),
        .wb_data   (wb_data),
        .alu_b     (alu_b)
    );

    dp_flag_reg u_flags (
        .clk      (clk),
        .rst      (rst),
        .flag_ld  (flag_ld),
        .alu_flags(alu_flags),
        .flags    (flags_q)
    );

    dp_pc_unit u_pc (
        .clk       (clk),
        .rst       (rst),
        .pc_ld     (pc_ld),
        .pc_jump   (pc_jump),
        .jump_addr (jump_addr),
        .stack_data(stack_data),
        .pc        (pc),
        .ret_addr  (ret_addr)
    );

    p_flag_reset_r10: assert property (@(posedge clk)
        rst |=> (!zero_flag && !carry_flag));
endmodule

// File: tb/dp_steer_bench.sv
module dp_steer_bench;
    logic clk = 1'b0;
    logic rst;
    logic [7:0] ext_data, const_data, shift_data, portb_data, imm_data, wb_data, alu_b;
    logic sel_const, sel_shift, sel_imm, alu_zero, alu_carry, flag_ld;
    logic zero_flag, carry_flag, pc_ld, pc_jump;
    logic [9:0] jump_addr, pc, stack_data, ret_addr;

    always #5 clk = ~clk;

    dp_steer u_dp_steer (.*);

    typedef struct {
        string      req;
        logic [7:0] wb;
        logic [7:0] b;
        logic [9:0] ret;
        logic [9:0] pc;
        logic       z;
        logic       c;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [9:0] m_pc;
    logic m_z, m_c;
    bit done = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(string req, logic r,
                        logic [7:0] ex, logic [7:0] co, logic [7:0] sh, logic sc, logic ss,
                        logic [7:0] pb, logic [7:0] im, logic si,
                        logic az, logic ac, logic fl,
                        logic pl, logic pj, logic [9:0] ja, logic [9:0] sd);
        item_t it;
        @(negedge clk);
        rst = r; ext_data = ex; const_data = co; shift_data = sh;
        sel_const = sc; sel_shift = ss; portb_data = pb; imm_data = im; sel_imm = si;
        alu_zero = az; alu_carry = ac; flag_ld = fl;
        pc_ld = pl; pc_jump = pj; jump_addr = ja; stack_data = sd;
        if (r) begin
            m_pc = '0; m_z = 1'b0; m_c = 1'b0;
        end else begin
            if (fl) begin m_z = az; m_c = ac; end
            if (pl) m_pc = pj ? ja : 10'(m_pc + 10'd1);
        end
        it.req = req;
        it.wb  = ss ? sh : (sc ? co : ex);
        it.b   = si ? im : pb;
        it.ret = 10'(sd + 10'd1);
        it.pc  = m_pc; it.z = m_z; it.c = m_c;
        q.push_back(it);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk(it.req, "wb_data",    int'(wb_data),    int'(it.wb));
                chk(it.req, "alu_b",      int'(alu_b),      int'(it.b));
                chk(it.req, "ret_addr",   int'(ret_addr),   int'(it.ret));
                chk(it.req, "pc",         int'(pc),         int'(it.pc));
                chk(it.req, "zero_flag",  int'(zero_flag),  int'(it.z));
                chk(it.req, "carry_flag", int'(carry_flag), int'(it.c));
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_pc = '0; m_z = 1'b0; m_c = 1'b0;
        // R10 reset, also with strobes high
        step("R10", 1, 8'h11, 8'h22, 8'h33, 0, 0, 8'h44, 8'h55, 0, 1, 1, 1, 1, 1, 10'h3AB, 10'd5);
        step("R10", 1, 8'h11, 8'h22, 8'h33, 0, 0, 8'h44, 8'h55, 0, 0, 0, 0, 0, 0, 10'd0, 10'd0);
        // R1 / R3 mux patterns
        step("R1", 0, 8'hA5, 8'h5A, 8'hFF, 0, 0, 8'h0F, 8'hF0, 0, 0, 0, 0, 0, 0, 10'd0, 10'd7);
        step("R1", 0, 8'hA5, 8'h5A, 8'hFF, 1, 0, 8'h0F, 8'hF0, 1, 0, 0, 0, 0, 0, 10'd0, 10'd8);
        // R2 shifter dominates both first-stage choices
        step("R2", 0, 8'hA5, 8'h5A, 8'h3C, 0, 1, 8'h81, 8'h18, 0, 0, 0, 0, 0, 0, 10'd0, 10'd9);
        step("R2", 0, 8'hA5, 8'h5A, 8'hC3, 1, 1, 8'h81, 8'h18, 1, 0, 0, 0, 0, 0, 10'd0, 10'd9);
        // R3 immediate select
        step("R3", 0, 8'h01, 8'h02, 8'h03, 0, 0, 8'h77, 8'h99, 1, 0, 0, 0, 0, 0, 10'd0, 10'd1);
        // R6 increments
        step("R6", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, 10'h155, 10'd2);
        step("R6", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, 10'h155, 10'd3);
        // R8 hold with jump high and pc_ld low
        step("R8", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 1, 10'h2AA, 10'd3);
        // R7 jump, same cycle as R4 flag load
        step("R7", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 1, 0, 1, 1, 1, 10'd1022, 10'd4);
        // R5 hold flags while ALU flags change; R6 step
        step("R5", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 0, 1, 0, 1, 0, 10'd0, 10'd4);
        // R6 wrap 1023 -> 0 with R4 flag load in same cycle
        step("R6", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 0, 1, 1, 1, 0, 10'd0, 10'd4);
        step("R4", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 1, 1, 1, 0, 0, 10'd0, 10'd4);
        step("R5", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 10'd0, 10'd4);
        // R9 return address wrap
        step("R9", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 10'd0, 10'd1023);
        step("R9", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 10'd0, 10'd511);
        // R10 reset after activity, with both strobes high
        step("R10", 1, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 1, 1, 1, 1, 1, 10'd300, 10'd0);
        step("R8", 0, 8'h00, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 10'd300, 10'd0);
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule